// File: doc/BRIEF.md
# Programmable Binary Tap Timer

This block is a binary prescaler timer with a fixed number of stages. It runs entirely on one system clock. A single-cycle count tick takes the place of an oscillator, and each accepted tick advances a binary counter by one. A two-bit tap select routes one of four counter stages to the output. Stage n is counter bit n-1, so that stage toggles at the tick rate divided by 2^n.

The block has two operating styles. In recycle style the chosen stage drives the output without a break, which makes the block a 2^n frequency divider. In single-cycle style the output changes level once, the first time the chosen stage goes high after a clear. It then keeps that level through every later counter wrap until the run is re-armed. A master reset re-arms the run, and so does any change of the mode input. Used with an inverted output, this behaves as a retriggerable one-shot: the output is high from the master reset pulse until the selected count is reached.

Two sources can clear the block. Master reset is synchronised inside the block. Power-on reset can be switched off with an enable input.

Top module: `tap_timer`

## Requirements
- R1: Each accepted tick advances the counter by exactly one. With no tick the counter holds its value. The counter wraps modulo 2^STAGES.
- R2: The tap select {sel_a_i, sel_b_i} picks a stage: 2'b00 picks stage 13, 2'b01 picks stage 10, 2'b10 picks stage 8 and 2'b11 picks stage 16 (all as parameter defaults). Stage n is counter bit n-1.
- R3: mr_i is active high and passes through a two-flop synchroniser. While the synchronised master reset is high, the counter and the single-cycle latch are cleared and ticks are not accepted.
- R4: With auto_rst_off_i=0, a high por_i clears the counter and the latch. With auto_rst_off_i=1, por_i has no effect on the count.
- R5: While any reset is in effect, q_o equals pol_i.
- R6: With mode_i=1, q_o equals the selected stage bit XOR pol_i.
- R7: With mode_i=0, q_o equals pol_i until the selected stage first goes high. From that tick on it equals the inverse of pol_i, and it keeps that value through later counter wraps until the next clear.
- R8: When mode_i differs from its value on the previous clock, the next clock edge clears the counter and the latch. A tick in that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| auto_rst_off_i | input | 1 | 1 makes por_i leave the count alone |
| mr_i | input | 1 | Master reset, active high, asynchronous to clk |
| tick_i | input | 1 | Single-cycle count enable |
| sel_a_i | input | 1 | Tap select, upper bit |
| sel_b_i | input | 1 | Tap select, lower bit |
| mode_i | input | 1 | 1 selects recycle style, 0 selects single-cycle style |
| pol_i | input | 1 | Output level while in reset |
| q_o | output | 1 | Timer output |

## Verification
The bench uses a six-stage configuration so that every tap can be run past a full counter wrap. It sweeps every combination of tap, mode and polarity, with both dense and sparse ticks. This catches a tap that maps to the wrong bit and an output that is off by one tick. It also catches a single-cycle output that releases when the counter wraps, which would appear as a second transition after the wrap. The bench targets three more faults: ticks accepted during master reset, which would fire the output early; a mode change that fails to re-arm, which would leave the output stuck after firing; and a power-on reset that clears the count while disabled, which would cause a phase jump in the divided output.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

    typedef enum logic [1:0] {
        TAP_SEL_0 = 2'b00,
        TAP_SEL_1 = 2'b01,
        TAP_SEL_2 = 2'b10,
        TAP_SEL_3 = 2'b11
    } tap_sel_e;

    typedef struct packed {
        logic clear;
        logic step;
    } cnt_ctrl_t;

    function automatic cnt_ctrl_t make_ctrl(logic rst, logic mode_chg, logic tick);
        cnt_ctrl_t c;
        c.clear = rst | mode_chg;
        c.step  = tick & ~c.clear;
        return c;
    endfunction

endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[DEPTH-2:0], d};
    end

    assign q = pipe_q[DEPTH-1];
endmodule

// File: rtl/stage_chain.sv
module stage_chain
    import tap_timer_pkg::*;
#(
    parameter int unsigned STAGES = 16,
    parameter int unsigned TAP0   = 13,
    parameter int unsigned TAP1   = 10,
    parameter int unsigned TAP2   = 8,
    parameter int unsigned TAP3   = 16
) (
    input  logic              clk,
    input  cnt_ctrl_t         ctrl,
    input  tap_sel_e          sel,
    output logic [STAGES-1:0] cnt_o,
    output logic              tap_o
);
    localparam int unsigned NTAPS = 4;
    localparam int unsigned TAPS [NTAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [STAGES-1:0] cnt_q;
    logic [NTAPS-1:0]  tap_vec;

    always_ff @(posedge clk) begin
        if (ctrl.clear)     cnt_q <= '0;
        else if (ctrl.step) cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign tap_vec[g] = cnt_q[TAPS[g]-1];
    end

    assign tap_o = tap_vec[sel];
    assign cnt_o = cnt_q;
endmodule

// File: rtl/fire_latch.sv
module fire_latch (
    input  logic clk,
    input  logic clear,
    input  logic tap,
    output logic fired_o
);
    logic hit_q;

    always_ff @(posedge clk) begin
        if (clear) hit_q <= 1'b0;
        else       hit_q <= hit_q | tap;
    end

    // The live tap is ORed in so the output turns in the same cycle the tap rises.
    assign fired_o = hit_q | tap;
endmodule

// File: rtl/tap_timer.sv
module tap_timer
    import tap_timer_pkg::*;
#(
    parameter int unsigned STAGES     = 16,
    parameter int unsigned TAP0       = 13,
    parameter int unsigned TAP1       = 10,
    parameter int unsigned TAP2       = 8,
    parameter int unsigned TAP3       = 16,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic auto_rst_off_i,
    input  logic mr_i,
    input  logic tick_i,
    input  logic sel_a_i,
    input  logic sel_b_i,
    input  logic mode_i,
    input  logic pol_i,
    output logic q_o
);
    logic              mr_s;
    logic              rst_int;
    logic              mode_q;
    logic              mode_chg;
    cnt_ctrl_t         ctrl;
    tap_sel_e          sel;
    logic [STAGES-1:0] cnt;
    logic              tap;
    logic              fired;

    sync_pipe #(.DEPTH(SYNC_DEPTH)) u_mr_sync (
        .clk (clk),
        .rst (por_i),
        .d   (mr_i),
        .q   (mr_s)
    );

    assign rst_int = mr_s | (por_i & ~auto_rst_off_i);

    always_ff @(posedge clk) mode_q <= mode_i;
    assign mode_chg = mode_i ^ mode_q;

    assign ctrl = make_ctrl(rst_int, mode_chg, tick_i);
    assign sel  = tap_sel_e'({sel_a_i, sel_b_i});

    stage_chain #(
        .STAGES (STAGES),
        .TAP0   (TAP0),
        .TAP1   (TAP1),
        .TAP2   (TAP2),
        .TAP3   (TAP3)
    ) u_chain (
        .clk   (clk),
        .ctrl  (ctrl),
        .sel   (sel),
        .cnt_o (cnt),
        .tap_o (tap)
    );

    fire_latch u_latch (
        .clk     (clk),
        .clear   (ctrl.clear),
        .tap     (tap),
        .fired_o (fired)
    );

    always_comb begin
        if (rst_int)     q_o = pol_i;
        else if (mode_i) q_o = tap ^ pol_i;
        else             q_o = fired ^ pol_i;
    end

    // R1: one step per accepted tick
    a_r1_step: assert property (@(posedge clk) disable iff (por_i)
        (!rst_int && !mode_chg && tick_i) |=> cnt == $past(cnt) + 1'b1);
    // R1: no tick, no change
    a_r1_hold: assert property (@(posedge clk) disable iff (por_i)
        (!rst_int && !mode_chg && !tick_i) |=> $stable(cnt));
    // R3: master reset clears and blocks ticks
    a_r3_clear: assert property (@(posedge clk) disable iff (por_i)
        mr_s |=> (cnt == '0) && !u_latch.hit_q);
    // R7: once fired, stays fired until a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (por_i)
        (u_latch.hit_q && !rst_int && !mode_chg) |=> u_latch.hit_q);
    // R8: mode change re-arms
    a_r8_rearm: assert property (@(posedge clk) disable iff (por_i)
        mode_chg |=> (cnt == '0) && !u_latch.hit_q);
endmodule

// File: tb/tb_tap_timer.sv
module tb_tap_timer;
    localparam int S = 6;

    logic clk = 1'b0;
    logic por = 1'b1, aoff = 1'b0, mr = 1'b0, tick = 1'b0;
    logic sa = 1'b0, sb = 1'b0, mode = 1'b0, pol = 1'b0;
    logic q;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tap_timer #(.STAGES(S), .TAP0(5), .TAP1(4), .TAP2(3), .TAP3(6)) dut (
        .clk(clk), .por_i(por), .auto_rst_off_i(aoff), .mr_i(mr), .tick_i(tick),
        .sel_a_i(sa), .sel_b_i(sb), .mode_i(mode), .pol_i(pol), .q_o(q));

    function automatic int tap_of(int s);
        case (s)
            0: return 5;
            1: return 4;
            2: return 3;
            default: return 6;
        endcase
    endfunction

    function automatic logic exp_q(int s, logic m, logic p, int n);
        int t = tap_of(s);
        logic b;
        if (m) b = logic'(((n % (1 << S)) >> (t - 1)) & 1);
        else   b = (n >= (1 << (t - 1)));
        return b ^ p;
    endfunction

    task automatic check(string req, logic exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b at %0t", req, q, exp, $time);
        end
    endtask

    task automatic pulse_tick(bit sparse);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (sparse) @(negedge clk);
    endtask

    task automatic master_reset();
        @(negedge clk) begin mr = 1'b1; tick = 1'b1; end
        repeat (6) @(negedge clk);
        check("R5", pol);
        mr = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R3", pol);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: q=%b expected completion", q);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R5", 1'b0);
        por = 1'b0;
        @(negedge clk);

        // R1 R2 R6 R7: full sweep over tap, mode, polarity, tick density
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 2; m++)
                for (int p = 0; p < 2; p++) begin
                    {sa, sb} = 2'(s); mode = logic'(m); pol = logic'(p);
                    master_reset();
                    for (int n = 1; n <= (1 << S) + 10; n++) begin
                        pulse_tick(bit'((n + s) % 3 == 0));
                        check(m ? "R6" : "R7", exp_q(s, logic'(m), logic'(p), n));
                    end
                end

        // R8: a mode change re-arms the single-cycle run and drops its tick
        {sa, sb} = 2'b10; mode = 1'b0; pol = 1'b1;
        master_reset();
        repeat (6) pulse_tick(1'b0);
        check("R7", 1'b0);
        @(negedge clk) begin mode = 1'b1; tick = 1'b1; end
        @(negedge clk) tick = 1'b0;
        check("R8", 1'b1);
        mode = 1'b0;
        @(negedge clk);
        check("R8", 1'b1);
        repeat (3) pulse_tick(1'b0);
        check("R8", 1'b1);
        pulse_tick(1'b0);
        check("R8", 1'b0);

        // R4: disabled power-on reset leaves the count alone
        {sa, sb} = 2'b10; mode = 1'b1; pol = 1'b0; aoff = 1'b1;
        @(negedge clk);
        master_reset();
        repeat (5) pulse_tick(1'b0);
        check("R4", exp_q(2, 1'b1, 1'b0, 5));
        por = 1'b1;
        repeat (3) @(negedge clk);
        check("R4", exp_q(2, 1'b1, 1'b0, 5));
        por = 1'b0;
        for (int n = 6; n <= 12; n++) begin
            pulse_tick(1'b0);
            check("R4", exp_q(2, 1'b1, 1'b0, n));
        end
        // R4: enabled power-on reset clears
        aoff = 1'b0; pol = 1'b1;
        @(negedge clk) por = 1'b1;
        repeat (2) @(negedge clk);
        check("R5", 1'b1);
        por = 1'b0;
        @(negedge clk);
        for (int n = 1; n <= 9; n++) begin
            pulse_tick(1'b0);
            check("R4", exp_q(2, 1'b1, 1'b1, n));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule